// File: doc/BRIEF.md
# A/D Conversion Start and Completion Interrupt Control

This block is the digital front end that decides when a multi-channel A/D converter begins a conversion, and that raises an interrupt request when results are waiting. A control write sets a scan-mode bit, a 3-bit start-mode field and an edge-inversion bit. The start mode can request no conversion, request one conversion at once, or pick one of six hardware trigger sources: four timer match lines and two external capture/match pins.

A picked trigger passes through a two-flop synchronizer. It is then XORed with the edge-inversion bit and fed to one rising-edge detector, so the inversion bit decides which edge of the source starts a conversion. The converter model reports each finished conversion with a strobe and a channel number. The block keeps a done flag for every channel. The interrupt request is the OR of the done flags gated by a per-channel enable mask. A read of a channel's result clears that channel's flag. Only the request level leaves the block, because the downstream interrupt controller applies its own enable.

Top module: `adc_trig_irq`

## Requirements
- R1: After reset, all done flags, the enable mask, the scan bit, the start mode and the inversion bit are zero, and `irq` and `conv_start` are low.
- R2: A control write of start mode 001 with the scan bit 0 makes `conv_start` high for exactly the one cycle after the write. The same write with the scan bit 1 gives no pulse.
- R3: Start mode m in 010..111 selects hardware source m-2. Index 0..3 is `tmr_match[0..3]` and index 4..5 is `cap_pin[0..1]`. With inversion 0, a 0-to-1 change on that source gives a one-cycle `conv_start` in the third cycle after the input changes (two synchronizer stages plus the output register).
- R4: With inversion 1, a hardware start comes from a 1-to-0 change of the selected source, with the same latency, and a 0-to-1 change gives none.
- R5: While the scan bit is 1, no hardware trigger gives a `conv_start`.
- R6: Start mode 000 gives no start on any trigger activity. In modes 010..111, activity on any source that is not selected gives no start.
- R7: Any control write reloads the edge history. Switching the source or the inversion bit so that the adjusted trigger goes from 0 to 1 gives no start.
- R8: A `conv_done` strobe with channel c sets done flag c on the next clock edge.
- R9: A `res_rd` with channel c clears done flag c on the next clock edge and leaves the other flags as they were.
- R10: When a `conv_done` and a `res_rd` name the same channel in the same cycle, that flag ends up set.
- R11: `irq` is high, with no register delay, exactly when some channel has both its done flag and its enable bit set. The enable mask is loaded by `ien_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_burst_in | input | 1 | Scan-mode bit; 1 blocks hardware and immediate starts |
| ctl_mode_in | input | 3 | Start mode: 000 none, 001 immediate, 010..111 hardware source |
| ctl_edge_inv_in | input | 1 | Trigger inversion; 1 selects the falling edge |
| ien_wr | input | 1 | Interrupt-enable mask write strobe |
| ien_in | input | NCH | Interrupt-enable mask value |
| tmr_match | input | 4 | Timer match lines, sources 0..3 |
| cap_pin | input | 2 | External capture/match pins, sources 4..5 |
| conv_done | input | 1 | Conversion-complete strobe from the converter |
| conv_ch | input | CHW | Channel of the completed conversion |
| res_rd | input | 1 | Result read strobe |
| res_ch | input | CHW | Channel whose result is read |
| conv_start | output | 1 | One-cycle conversion start pulse |
| done_flags | output | NCH | Per-channel done flags |
| irq | output | 1 | Interrupt request level |

## Verification
Flag bookkeeping can see two events in the same cycle: a completion setting a channel's flag and a result read clearing it. The bench drives `conv_done` and `res_rd` on the same edge, once for the same channel and once for different channels. It expects the shared channel to stay set, and in the other case one flag to rise while the other falls. On the trigger side, a control write can land while the newly selected source already reads high. The bench provokes this and expects no start pulse in the following cycles.

// File: rtl/adc_trig_irq.sv
module adc_trig_irq #(
  parameter int NCH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_wr,
  input  logic                     ctl_burst_in,
  input  logic [2:0]               ctl_mode_in,
  input  logic                     ctl_edge_inv_in,
  input  logic                     ien_wr,
  input  logic [NCH-1:0]           ien_in,
  input  logic [3:0]               tmr_match,
  input  logic [1:0]               cap_pin,
  input  logic                     conv_done,
  input  logic [$clog2(NCH)-1:0]   conv_ch,
  input  logic                     res_rd,
  input  logic [$clog2(NCH)-1:0]   res_ch,
  output logic                     conv_start,
  output logic [NCH-1:0]           done_flags,
  output logic                     irq
);
  localparam int CHW  = $clog2(NCH);
  localparam int NSRC = 6;

  logic            burst_q, inv_q, hist_q, armed_q;
  logic [2:0]      mode_q;
  logic [NCH-1:0]  ien_q;
  logic [NSRC-1:0] sync1_q, sync2_q;
  logic [2:0]      src_idx;
  logic            hw_mode, trig_sel, trig_adj, hw_edge, imm_req;

  assign hw_mode  = mode_q >= 3'd2;
  assign src_idx  = mode_q - 3'd2;
  assign trig_sel = hw_mode ? sync2_q[src_idx] : 1'b0;
  assign trig_adj = trig_sel ^ inv_q;
  assign hw_edge  = armed_q && hw_mode && !burst_q && trig_adj && !hist_q;
  assign imm_req  = ctl_wr && !ctl_burst_in && ctl_mode_in == 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_q    <= 1'b0;
      mode_q     <= '0;
      inv_q      <= 1'b0;
      ien_q      <= '0;
      sync1_q    <= '0;
      sync2_q    <= '0;
      hist_q     <= 1'b0;
      armed_q    <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      if (ctl_wr) begin
        burst_q <= ctl_burst_in;
        mode_q  <= ctl_mode_in;
        inv_q   <= ctl_edge_inv_in;
      end
      if (ien_wr) ien_q <= ien_in;
      sync1_q    <= {cap_pin, tmr_match};
      sync2_q    <= sync1_q;
      hist_q     <= trig_adj;
      armed_q    <= !ctl_wr;
      conv_start <= imm_req || hw_edge;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    wire set_c = conv_done && conv_ch == CHW'(c);
    wire clr_c = res_rd && res_ch == CHW'(c);
    always_ff @(posedge clk) begin
      if (!rst_n)     done_flags[c] <= 1'b0;
      else if (set_c) done_flags[c] <= 1'b1;
      else if (clr_c) done_flags[c] <= 1'b0;
    end
  end

  assign irq = |(done_flags & ien_q);
endmodule

module adc_trig_irq_chk #(
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_wr,
  input logic                   ctl_burst_in,
  input logic                   burst_q,
  input logic [NCH-1:0]         ien_q,
  input logic                   conv_done,
  input logic [$clog2(NCH)-1:0] conv_ch,
  input logic                   res_rd,
  input logic [$clog2(NCH)-1:0] res_ch,
  input logic                   conv_start,
  input logic [NCH-1:0]         done_flags,
  input logic                   irq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (done_flags == '0 && !conv_start && ien_q == '0));

  p_scan_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(ctl_wr ? !ctl_burst_in : !burst_q));

  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flags[$past(conv_ch)]);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !(conv_done && conv_ch == res_ch)) |=> !done_flags[$past(res_ch)]);

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && conv_done && conv_ch == res_ch) |=> done_flags[$past(res_ch)]);

  p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((done_flags & ien_q) != '0));
endmodule

bind adc_trig_irq adc_trig_irq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_burst_in(ctl_burst_in),
  .burst_q(burst_q), .ien_q(ien_q), .conv_done(conv_done), .conv_ch(conv_ch),
  .res_rd(res_rd), .res_ch(res_ch), .conv_start(conv_start),
  .done_flags(done_flags), .irq(irq)
);

// File: tb/adc_trig_irq_tb.sv
module adc_trig_irq_tb_top;
  localparam int NCH = 8;
  localparam int CHW = $clog2(NCH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_burst_in = 0, ctl_edge_inv_in = 0, ien_wr = 0;
  logic [2:0] ctl_mode_in = '0;
  logic [NCH-1:0] ien_in = '0;
  logic [5:0] trig = '0;
  logic conv_done = 0, res_rd = 0;
  logic [CHW-1:0] conv_ch = '0, res_ch = '0;
  logic conv_start, irq;
  logic [NCH-1:0] done_flags;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  adc_trig_irq #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_burst_in(ctl_burst_in),
    .ctl_mode_in(ctl_mode_in), .ctl_edge_inv_in(ctl_edge_inv_in),
    .ien_wr(ien_wr), .ien_in(ien_in), .tmr_match(trig[3:0]), .cap_pin(trig[5:4]),
    .conv_done(conv_done), .conv_ch(conv_ch), .res_rd(res_rd), .res_ch(res_ch),
    .conv_start(conv_start), .done_flags(done_flags), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic b, input logic [2:0] m, input logic inv, output logic imm);
    @(negedge clk);
    ctl_wr = 1; ctl_burst_in = b; ctl_mode_in = m; ctl_edge_inv_in = inv;
    @(negedge clk);
    imm = conv_start;
    ctl_wr = 0;
  endtask

  task automatic observe(output int cnt, output int pos);
    cnt = 0; pos = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (conv_start) begin cnt++; pos = k; end
    end
  endtask

  task automatic drive_src(input int s, input logic v, output int cnt, output int pos);
    @(negedge clk);
    trig[s] = v;
    observe(cnt, pos);
  endtask

  task automatic wr_ien(input logic [NCH-1:0] v);
    @(negedge clk); ien_wr = 1; ien_in = v;
    @(negedge clk); ien_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic imm;
    int cnt, pos;
    logic [NCH-1:0] exp_f, en;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", done_flags, 0);
    check("R1 irq", irq, 0);
    check("R1 start", conv_start, 0);
    wr_ien('1);
    check("R1 irq after enabling with no flags", irq, 0);

    // R2 immediate start
    wr_ctl(0, 3'd1, 0, imm);
    check("R2 immediate pulse", imm, 1);
    @(negedge clk); check("R2 pulse one cycle", conv_start, 0);
    wr_ctl(1, 3'd1, 0, imm);
    check("R2 no pulse with scan bit", imm, 0);
    @(negedge clk); check("R2 still none", conv_start, 0);

    // R6 mode 000 ignores triggers
    wr_ctl(0, 3'd0, 0, imm);
    for (int s = 0; s < 6; s++) begin
      drive_src(s, 1, cnt, pos); check("R6 mode0 rise", cnt, 0);
      drive_src(s, 0, cnt, pos); check("R6 mode0 fall", cnt, 0);
    end

    // R3 R4 R6 sweep of mode, inversion and source
    for (int m = 2; m < 8; m++)
      for (int inv = 0; inv < 2; inv++)
        for (int s = 0; s < 6; s++) begin
          wr_ctl(0, 3'(m), 1'(inv), imm);
          repeat (3) @(negedge clk);
          drive_src(s, 1, cnt, pos);
          if (inv == 0 && s == m - 2) begin
            check("R3 rising count", cnt, 1); check("R3 rising latency", pos, 3);
          end else check("R4 R6 no start on rise", cnt, 0);
          drive_src(s, 0, cnt, pos);
          if (inv == 1 && s == m - 2) begin
            check("R4 falling count", cnt, 1); check("R4 falling latency", pos, 3);
          end else check("R3 R6 no start on fall", cnt, 0);
        end

    // R5 scan bit blocks hardware triggers
    for (int m = 2; m < 8; m++) begin
      wr_ctl(1, 3'(m), 0, imm);
      repeat (3) @(negedge clk);
      drive_src(m - 2, 1, cnt, pos); check("R5 scan blocks", cnt, 0);
      drive_src(m - 2, 0, cnt, pos); check("R5 scan blocks", cnt, 0);
    end

    // R7 source switch onto a high line, and inversion toggle
    wr_ctl(0, 3'd2, 0, imm);
    @(negedge clk); trig[1] = 1;
    repeat (4) @(negedge clk);
    wr_ctl(0, 3'd3, 0, imm);
    observe(cnt, pos); check("R7 switch source no false start", cnt, 0);
    @(negedge clk); trig[1] = 0;
    repeat (4) @(negedge clk);
    wr_ctl(0, 3'd3, 1, imm);
    observe(cnt, pos); check("R7 flip inversion no false start", cnt, 0);
    drive_src(1, 1, cnt, pos); check("R7 detector still live", cnt, 0);
    drive_src(1, 0, cnt, pos); check("R7 detector still live", cnt, 1);

    // R8 R9 R11 flag and interrupt sweep
    for (int f = 0; f < 256; f++) begin
      exp_f = NCH'(f);
      en = NCH'(f * 7) ^ NCH'(8'hA5);
      wr_ien(en);
      for (int c = 0; c < NCH; c++)
        if (exp_f[c]) begin
          @(negedge clk); conv_done = 1; conv_ch = CHW'(c);
          @(negedge clk); conv_done = 0;
        end
      check("R8 flags set", done_flags, exp_f);
      check("R11 irq", irq, (exp_f & en) != 0);
      for (int c = 0; c < NCH; c++)
        if (exp_f[c]) begin
          @(negedge clk); res_rd = 1; res_ch = CHW'(c);
          @(negedge clk); res_rd = 0;
          exp_f[c] = 1'b0;
          check("R9 clear one", done_flags, exp_f);
          check("R11 irq follows", irq, (exp_f & en) != 0);
        end
    end

    // R10 same-cycle set and clear
    wr_ien('1);
    @(negedge clk); conv_done = 1; conv_ch = 3;
    @(negedge clk); conv_ch = 3; res_rd = 1; res_ch = 3;
    @(negedge clk); conv_done = 0; res_rd = 0;
    check("R10 same channel stays set", done_flags, 8'h08);
    @(negedge clk); conv_done = 1; conv_ch = 2; res_rd = 1; res_ch = 3;
    @(negedge clk); conv_done = 0; res_rd = 0;
    check("R10 different channels", done_flags, 8'h04);
    check("R11 irq on ch2", irq, 1);
    wr_ien(8'hFB);
    check("R11 masked", irq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule